// File: doc/BRIEF.md
# DMA Byte Counter and Burst Controller

This block keeps the setup and the running byte count for the DMA channel of one full-speed USB device endpoint. A byte-wide command port reaches two 16-bit registers: a configuration word and a byte count. The configuration word holds the channel enable, the end-of-transfer options, the target endpoint index and the burst size. The byte count holds the number of bytes programmed for one transfer. A command byte selects a register and its direction. The data bytes that follow travel low byte first.

Writing the enable as 1 copies the programmed count into a working down-counter. While the channel runs, the block raises a DMA request. It reports how many bytes remain in the current burst and marks the last byte of each burst. Each acknowledged byte takes one from the working count. The transfer ends in one of two ways: the count reaches zero, or a short or empty OUT packet arrives. Each of these has its own enable. At the end, the block drops the enable and emits a one-cycle end-of-transfer pulse. A USB bus reset stops the channel and leaves every other setting untouched.

Top module: `usb_dma_ctl`

## Requirements
- R1: After synchronous reset (rst_n low at a clock edge), every register field and the working count are 0. dma_req, eot, burst_bytes, burst_last and dat_rdata are then 0.
- R2: Command 0xF0 writes the configuration word and 0xF1 reads it, two data bytes each, low byte first. The bit positions are: bit 15 count-end enable, bit 14 short-packet mode, bits 7:4 endpoint index (driven on dma_ep), bit 3 enable, bits 1:0 burst select. Bits 13:8 and bit 2 read 0 and ignore writes.
- R3: Command 0xF2 writes the 16-bit programmed count, low byte first. Command 0xF3 reads the working (remaining) count, low byte first.
- R4: Every write of the configuration low byte with bit 3 = 1 sets the enable and reloads the working count from the programmed count.
- R5: dma_req is high exactly when the enable is 1 and either the working count is nonzero or the count-end enable is 0.
- R6: An edge with byte_ack high while dma_req is high lowers the working count by one. The count never goes below zero. byte_ack has no effect while dma_req is low.
- R7: The burst select sets the burst size: 00 gives 1 byte, 01 gives 4, 10 gives 8, 11 gives 16. burst_last is high when burst_bytes is 1.
- R8: While dma_req is high, burst_bytes is the number of bytes left in the current burst. When the count-end enable is 1, this is limited to the working count, so the final burst is truncated. burst_bytes is 0 while dma_req is low.
- R9: The count-end enable is 1 and the working count is 0 while enabled. At the next edge, the enable clears and eot is high for one cycle.
- R10: short_pkt is sampled high while enabled, with short-packet mode 1 and ep_is_out 1. At that edge, the enable clears and eot is high for one cycle. With ep_is_out 0, or with short-packet mode 0, short_pkt is ignored.
- R11: Writing the enable as 0 stops the transfer without an eot pulse and keeps the working count.
- R12: bus_reset clears only the enable. It does not raise eot, and all other configuration fields and both counts keep their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| cmd_we | input | 1 | Command byte strobe |
| cmd_code | input | 8 | Command byte |
| dat_we | input | 1 | Data byte write strobe |
| dat_wdata | input | 8 | Data byte to write |
| dat_re | input | 1 | Data byte read advance strobe |
| dat_rdata | output | 8 | Data byte currently readable |
| byte_ack | input | 1 | One byte moved by the DMA engine |
| short_pkt | input | 1 | Short or empty packet received |
| ep_is_out | input | 1 | Endpoint is receiving (OUT) |
| bus_reset | input | 1 | USB bus reset seen |
| dma_req | output | 1 | DMA request |
| burst_bytes | output | 5 | Bytes left in the current burst |
| burst_last | output | 1 | Current byte closes the burst |
| eot | output | 1 | End-of-transfer pulse |
| dma_ep | output | 4 | Target endpoint index |

## Verification
All outputs come from registers. Register-port effects appear in the cycle after the strobing edge:
- a read pointer advance shows on dat_rdata then;
- a count decrement shows on dma_req and burst_bytes then;
- a short-packet end raises eot at the edge that samples short_pkt.

A count-driven end needs one extra edge: eot rises one edge after the edge that brought the count to zero. A behavioural model in the bench advances on the same edges and is compared at every falling edge. Directed checks drive inputs 2 ns after a rising edge and read results at that same point in the following cycle. This follows the one-edge latency listed above.

// File: rtl/usbdma_pkg.sv
`timescale 1ns/1ps
// Shared command codes, configuration layout and burst-size decode for the
// USB DMA counter block. Assumes a byte-wide command port.
package usbdma_pkg;
    localparam logic [7:0] CMD_CFG_WR = 8'hF0;
    localparam logic [7:0] CMD_CFG_RD = 8'hF1;
    localparam logic [7:0] CMD_CNT_WR = 8'hF2;
    localparam logic [7:0] CMD_CNT_RD = 8'hF3;

    typedef struct packed {
        logic       cnt_eot_en;
        logic       short_mode;
        logic [3:0] ep_idx;
        logic [1:0] burst_sel;
    } dma_cfg_t;

    // Burst size in bytes for a burst select code
    function automatic logic [4:0] burst_of(input logic [1:0] sel);
        case (sel)
            2'b00:   burst_of = 5'd1;
            2'b01:   burst_of = 5'd4;
            2'b10:   burst_of = 5'd8;
            default: burst_of = 5'd16;
        endcase
    endfunction
endpackage

// File: rtl/usbdma_regs.sv
`timescale 1ns/1ps
// Command decoder and register file. Holds the configuration fields (except
// the enable, which lives in the transfer engine) and the programmed count.
// Assumes at most one of cmd_we / dat_we / dat_re per cycle; cmd_we wins.
module usbdma_regs
    import usbdma_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cmd_we,
    input  logic [7:0]       cmd_code,
    input  logic             dat_we,
    input  logic [7:0]       dat_wdata,
    input  logic             dat_re,
    output logic [7:0]       dat_rdata,
    input  logic             en,
    input  logic [CNT_W-1:0] remaining,
    output dma_cfg_t         cfg,
    output logic [CNT_W-1:0] cnt_prog,
    output logic             en_wr,
    output logic             en_wval
);
    localparam int NB    = CNT_W / 8;
    localparam int PTR_W = $clog2(NB + 2);
    localparam logic [PTR_W-1:0] CFG_LIM = PTR_W'(2);
    localparam logic [PTR_W-1:0] CNT_LIM = PTR_W'(NB);

    logic [7:0]       sel;
    logic [PTR_W-1:0] ptr;
    logic [PTR_W-1:0] lim;
    logic             is_cnt, wr_ok, rd_ok;
    logic [15:0]      cfg_word;

    // Byte limit and accepted-strobe decode for the selected command
    always_comb begin
        is_cnt = (sel == CMD_CNT_WR) || (sel == CMD_CNT_RD);
        lim    = is_cnt ? CNT_LIM : CFG_LIM;
        wr_ok  = !cmd_we && dat_we && (ptr < lim) &&
                 ((sel == CMD_CFG_WR) || (sel == CMD_CNT_WR));
        rd_ok  = !cmd_we && dat_re && (ptr < lim) &&
                 ((sel == CMD_CFG_RD) || (sel == CMD_CNT_RD));
        en_wr  = wr_ok && (sel == CMD_CFG_WR) && (ptr == '0);
        en_wval = dat_wdata[3];
    end

    // Track the selected command and the byte pointer within it
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sel <= '0;
            ptr <= '0;
        end else if (cmd_we) begin
            sel <= cmd_code;
            ptr <= '0;
        end else if (wr_ok || rd_ok) begin
            ptr <= ptr + 1'b1;
        end
    end

    // Store configuration fields and programmed count bytes
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg      <= '0;
            cnt_prog <= '0;
        end else if (wr_ok) begin
            if (sel == CMD_CFG_WR) begin
                if (ptr == '0) begin
                    cfg.ep_idx    <= dat_wdata[7:4];
                    cfg.burst_sel <= dat_wdata[1:0];
                end else begin
                    cfg.cnt_eot_en <= dat_wdata[7];
                    cfg.short_mode <= dat_wdata[6];
                end
            end else begin
                cnt_prog[8*ptr +: 8] <= dat_wdata;
            end
        end
    end

    // Build read-back data for the current byte
    always_comb begin
        cfg_word = {cfg.cnt_eot_en, cfg.short_mode, 6'b0, cfg.ep_idx,
                    en, 1'b0, cfg.burst_sel};
        dat_rdata = 8'h00;
        if (sel == CMD_CFG_RD && ptr < CFG_LIM)
            dat_rdata = cfg_word[8*ptr +: 8];
        else if (sel == CMD_CNT_RD && ptr < CNT_LIM)
            dat_rdata = remaining[8*ptr +: 8];
    end

    // R3
    cnt_lo_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!cmd_we && dat_we && sel == CMD_CNT_WR && ptr == '0)
        |=> (cnt_prog[7:0] == $past(dat_wdata)));

    // R2
    rsvd_ro_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sel == CMD_CFG_RD && ptr == PTR_W'(1)) |-> (dat_rdata[5:0] == 6'b0));
endmodule

// File: rtl/usbdma_xfer.sv
`timescale 1ns/1ps
// Transfer engine: owns the enable and the working down-counter, tracks the
// position inside a burst and decides end of transfer. Assumes byte_ack is
// only meaningful while dma_req is high.
module usbdma_xfer
    import usbdma_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  dma_cfg_t         cfg,
    input  logic [CNT_W-1:0] cnt_prog,
    input  logic             en_wr,
    input  logic             en_wval,
    input  logic             byte_ack,
    input  logic             short_pkt,
    input  logic             ep_is_out,
    input  logic             bus_reset,
    output logic             en,
    output logic [CNT_W-1:0] remaining,
    output logic             dma_req,
    output logic [4:0]       burst_bytes,
    output logic             burst_last,
    output logic             eot
);
    logic [3:0] bpos;
    logic [4:0] bsize, room;
    logic       short_hit, eot_cond;

    // Request, burst window and end-of-transfer decode
    always_comb begin
        bsize     = burst_of(cfg.burst_sel);
        room      = bsize - {1'b0, bpos};
        dma_req   = en && ((remaining != '0) || !cfg.cnt_eot_en);
        if (!dma_req)
            burst_bytes = 5'd0;
        else if (cfg.cnt_eot_en && (remaining < CNT_W'(room)))
            burst_bytes = remaining[4:0];
        else
            burst_bytes = room;
        burst_last = (burst_bytes == 5'd1);
        short_hit  = cfg.short_mode && ep_is_out && short_pkt;
        eot_cond   = en && ((cfg.cnt_eot_en && remaining == '0) || short_hit);
    end

    // Enable, working count, burst position and eot pulse
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en        <= 1'b0;
            remaining <= '0;
            bpos      <= '0;
            eot       <= 1'b0;
        end else begin
            eot <= 1'b0;
            if (bus_reset) begin
                en   <= 1'b0;
                bpos <= '0;
            end else if (en_wr) begin
                en <= en_wval;
                if (en_wval) begin
                    remaining <= cnt_prog;
                    bpos      <= '0;
                end
            end else if (eot_cond) begin
                en   <= 1'b0;
                eot  <= 1'b1;
                bpos <= '0;
            end else if (dma_req && byte_ack) begin
                if (remaining != '0)
                    remaining <= remaining - 1'b1;
                bpos <= burst_last ? 4'd0 : bpos + 4'd1;
            end
        end
    end

    // R9
    cnt_eot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (en && cfg.cnt_eot_en && remaining == '0 && !bus_reset && !en_wr)
        |=> (eot && !en));

    // R10
    short_eot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (en && cfg.short_mode && ep_is_out && short_pkt && !bus_reset && !en_wr)
        |=> (eot && !en));

    // R12
    bus_rst_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bus_reset |=> (!en && !eot && $stable(remaining)));

    // R6
    dec_one_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (dma_req && byte_ack && remaining != '0 && !bus_reset && !en_wr && !eot_cond)
        |=> (remaining == $past(remaining) - 1'b1));

    // R8
    trunc_chk: assert property (@(posedge clk) disable iff (!rst_n)
        dma_req |-> (burst_bytes != 5'd0 &&
                     (!cfg.cnt_eot_en || CNT_W'(burst_bytes) <= remaining)));

    // R4
    reload_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (en_wr && en_wval && !bus_reset) |=> (en && remaining == $past(cnt_prog)));
endmodule

// File: rtl/usb_dma_ctl.sv
`timescale 1ns/1ps
// Top of the USB endpoint DMA byte counter and burst controller. Joins the
// register/command block with the transfer engine. Assumes CNT_W is a
// multiple of 8.
module usb_dma_ctl
    import usbdma_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       cmd_we,
    input  logic [7:0] cmd_code,
    input  logic       dat_we,
    input  logic [7:0] dat_wdata,
    input  logic       dat_re,
    output logic [7:0] dat_rdata,
    input  logic       byte_ack,
    input  logic       short_pkt,
    input  logic       ep_is_out,
    input  logic       bus_reset,
    output logic       dma_req,
    output logic [4:0] burst_bytes,
    output logic       burst_last,
    output logic       eot,
    output logic [3:0] dma_ep
);
    dma_cfg_t         cfg;
    logic [CNT_W-1:0] cnt_prog, remaining;
    logic             en, en_wr, en_wval;

    usbdma_regs #(.CNT_W(CNT_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .cmd_we(cmd_we), .cmd_code(cmd_code),
        .dat_we(dat_we), .dat_wdata(dat_wdata), .dat_re(dat_re),
        .dat_rdata(dat_rdata), .en(en), .remaining(remaining), .cfg(cfg),
        .cnt_prog(cnt_prog), .en_wr(en_wr), .en_wval(en_wval)
    );

    usbdma_xfer #(.CNT_W(CNT_W)) u_xfer (
        .clk(clk), .rst_n(rst_n), .cfg(cfg), .cnt_prog(cnt_prog),
        .en_wr(en_wr), .en_wval(en_wval), .byte_ack(byte_ack),
        .short_pkt(short_pkt), .ep_is_out(ep_is_out), .bus_reset(bus_reset),
        .en(en), .remaining(remaining), .dma_req(dma_req),
        .burst_bytes(burst_bytes), .burst_last(burst_last), .eot(eot)
    );

    // Endpoint index is a plain view of the configuration field
    assign dma_ep = cfg.ep_idx;
endmodule

// File: tb/usb_dma_ctl_tb.sv
`timescale 1ns/1ps
module usb_dma_ctl_tb;
    logic       clk = 0, rst_n = 0;
    logic       cmd_we = 0, dat_we = 0, dat_re = 0;
    logic [7:0] cmd_code = 0, dat_wdata = 0, dat_rdata;
    logic       byte_ack = 0, short_pkt = 0, ep_is_out = 0, bus_reset = 0;
    logic       dma_req, burst_last, eot;
    logic [4:0] burst_bytes;
    logic [3:0] dma_ep;

    int checks = 0, errors = 0, eot_seen = 0, cycles = 0;
    bit started = 0, done = 0;

    usb_dma_ctl u_dut (.*);

    always #5 clk = ~clk;

    task automatic chk(input string tag, input int got, input int exp);
        checks++;
        if (got != exp) begin
            errors++;
            $display("FAIL %s got %0h expected %0h at %0t", tag, got, exp, $time);
        end
    endtask

    // ---------------- behavioural reference model ----------------
    int m_sel, m_ptr, m_ep, m_bsel, m_cnt, m_rem, m_bpos;
    bit m_ceot, m_spm, m_en, m_eot;

    function automatic int bsz(input int s);
        return (s == 0) ? 1 : (4 << (s - 1));
    endfunction
    function automatic bit e_req();
        return m_en && (m_rem != 0 || !m_ceot);
    endfunction
    function automatic int e_bb();
        int room;
        if (!e_req()) return 0;
        room = bsz(m_bsel) - m_bpos;
        return (m_ceot && m_rem < room) ? m_rem : room;
    endfunction
    function automatic int e_rd();
        int w;
        w = (m_ceot << 15) | (m_spm << 14) | (m_ep << 4) | (m_en << 3) | m_bsel;
        if (m_sel == 'hF1 && m_ptr < 2) return (w >> (8*m_ptr)) & 255;
        if (m_sel == 'hF3 && m_ptr < 2) return (m_rem >> (8*m_ptr)) & 255;
        return 0;
    endfunction

    always @(posedge clk) begin : model
        bit wr_ok, rd_ok, req, blast, eotc;
        started = 1;
        if (!rst_n) begin
            m_sel = 0; m_ptr = 0; m_ep = 0; m_bsel = 0; m_cnt = 0; m_rem = 0;
            m_bpos = 0; m_ceot = 0; m_spm = 0; m_en = 0; m_eot = 0;
        end else begin
            wr_ok = !cmd_we && dat_we && m_ptr < 2 && (m_sel == 'hF0 || m_sel == 'hF2);
            rd_ok = !cmd_we && dat_re && m_ptr < 2 && (m_sel == 'hF1 || m_sel == 'hF3);
            req   = e_req();
            blast = (e_bb() == 1);
            eotc  = m_en && ((m_ceot && m_rem == 0) || (m_spm && ep_is_out && short_pkt));
            m_eot = 0;
            if (bus_reset) begin
                m_en = 0; m_bpos = 0;
            end else if (wr_ok && m_sel == 'hF0 && m_ptr == 0) begin
                m_en = dat_wdata[3];
                if (dat_wdata[3]) begin m_rem = m_cnt; m_bpos = 0; end
            end else if (eotc) begin
                m_en = 0; m_eot = 1; m_bpos = 0;
            end else if (req && byte_ack) begin
                if (m_rem > 0) m_rem--;
                m_bpos = blast ? 0 : m_bpos + 1;
            end
            if (wr_ok) begin
                if (m_sel == 'hF0) begin
                    if (m_ptr == 0) begin m_ep = dat_wdata[7:4]; m_bsel = dat_wdata[1:0]; end
                    else begin m_ceot = dat_wdata[7]; m_spm = dat_wdata[6]; end
                end else if (m_ptr == 0) m_cnt = (m_cnt & 'hFF00) | dat_wdata;
                else m_cnt = (m_cnt & 'h00FF) | (dat_wdata << 8);
            end
            if (cmd_we) begin m_sel = cmd_code; m_ptr = 0; end
            else if (wr_ok || rd_ok) m_ptr++;
        end
    end

    // Per-cycle comparison away from the rising edge
    always @(negedge clk) begin
        if (started && !done) begin
            chk("R5 dma_req", dma_req, e_req());
            chk("R8 burst_bytes", burst_bytes, e_bb());
            chk("R7 burst_last", burst_last, e_bb() == 1);
            chk("R9 eot", eot, m_eot);
            chk("R2 dat_rdata", dat_rdata, e_rd());
            chk("R2 dma_ep", dma_ep, m_ep);
            if (eot) eot_seen++;
        end
    end

    // Watchdog
    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000 && !done) begin
            done = 1;
            errors++; checks++;
            $display("FAIL watchdog expired");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    // ---------------- stimulus tasks ----------------
    task automatic cmd(input logic [7:0] c);
        @(posedge clk); #2 cmd_we = 1; cmd_code = c;
        @(posedge clk); #2 cmd_we = 0;
    endtask
    task automatic wbyte(input logic [7:0] d);
        @(posedge clk); #2 dat_we = 1; dat_wdata = d;
        @(posedge clk); #2 dat_we = 0;
    endtask
    task automatic write16(input logic [7:0] c, input logic [15:0] v);
        cmd(c); wbyte(v[7:0]); wbyte(v[15:8]);
    endtask
    task automatic read16(input logic [7:0] c, output logic [15:0] v);
        cmd(c);
        v[7:0] = dat_rdata;
        @(posedge clk); #2 dat_re = 1;
        @(posedge clk); #2 dat_re = 0;
        v[15:8] = dat_rdata;
    endtask
    task automatic acks(input int n);
        @(posedge clk); #2 byte_ack = 1;
        repeat (n) @(posedge clk);
        #2 byte_ack = 0;
    endtask
    task automatic pulse_short();
        @(posedge clk); #2 short_pkt = 1;
        @(posedge clk); #2 short_pkt = 0;
    endtask

    logic [15:0] rv;
    initial begin
        repeat (3) @(posedge clk);
        #2;
        // R1 reset state
        chk("R1 dma_req", dma_req, 0);
        chk("R1 eot", eot, 0);
        chk("R1 burst_bytes", burst_bytes, 0);
        rst_n = 1;
        read16(8'hF1, rv); chk("R1 cfg", rv, 16'h0000);
        read16(8'hF3, rv); chk("R1 cnt", rv, 16'h0000);

        // Reserved bits ignored
        write16(8'hF0, 16'h7F06);
        read16(8'hF1, rv); chk("R2 reserved", rv, 16'h4002);

        // Count 5, burst 4, count-end enabled
        write16(8'hF2, 16'd5);
        write16(8'hF0, 16'h8039);
        read16(8'hF1, rv); chk("R2 cfg", rv, 16'h8039);
        read16(8'hF3, rv); chk("R4 reload", rv, 16'd5);
        chk("R7 burst4", burst_bytes, 4);
        acks(4);
        chk("R8 truncated", burst_bytes, 1);
        chk("R7 last", burst_last, 1);
        acks(1);
        @(posedge clk); #2;
        chk("R9 eot pulse", eot, 1);
        chk("R9 req low", dma_req, 0);
        read16(8'hF3, rv); chk("R3 remaining", rv, 16'd0);
        read16(8'hF1, rv); chk("R9 en cleared", rv, 16'h8031);

        // Burst 16, count 20, acks with gaps
        write16(8'hF2, 16'd20);
        write16(8'hF0, 16'h800B);
        chk("R7 burst16", burst_bytes, 16);
        acks(16);
        chk("R8 truncated 4", burst_bytes, 4);
        acks(2); repeat (3) @(posedge clk); acks(2);
        repeat (3) @(posedge clk);

        // Single-cycle mode
        write16(8'hF2, 16'd3);
        write16(8'hF0, 16'h8008);
        #1 chk("R7 single", burst_last, 1);
        acks(3);
        repeat (3) @(posedge clk); #2;
        chk("R9 eot count", eot_seen, 3);

        // Count-end disabled: request persists at zero, no underflow
        write16(8'hF0, 16'h0009);
        acks(10);
        read16(8'hF3, rv); chk("R6 no underflow", rv, 16'd0);
        chk("R5 req at zero", dma_req, 1);
        write16(8'hF0, 16'h0001);
        chk("R11 stopped", dma_req, 0);
        chk("R11 no eot", eot_seen, 3);

        // Short packet handling
        write16(8'hF2, 16'd100);
        write16(8'hF0, 16'hC008);
        ep_is_out = 0; pulse_short();
        read16(8'hF1, rv); chk("R10 ignored on IN", rv[3], 1);
        ep_is_out = 1; pulse_short();
        chk("R10 short eot", eot, 1);
        write16(8'hF0, 16'h8008);
        pulse_short();
        read16(8'hF1, rv); chk("R10 ignored mode off", rv[3], 1);

        // Disable mid-transfer then re-enable
        acks(10);
        write16(8'hF0, 16'h8000);
        read16(8'hF3, rv); chk("R11 kept count", rv, 16'd90);
        write16(8'hF0, 16'h8008);
        read16(8'hF3, rv); chk("R4 re-enable reload", rv, 16'd100);

        // Bus reset clears only enable
        write16(8'hF0, 16'hC0F9);
        acks(3);
        @(posedge clk); #2 bus_reset = 1;
        @(posedge clk); #2 bus_reset = 0;
        read16(8'hF1, rv); chk("R12 cfg kept", rv, 16'hC0F1);
        read16(8'hF3, rv); chk("R12 count kept", rv, 16'd97);
        chk("R12 no eot", eot_seen, 4);

        repeat (2) @(posedge clk);
        done = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule